// File: doc/BRIEF.md
# First-Come First-Served Channel Arbiter

This block lets a parameterised number of requesters share one output channel, and it serves them strictly in the order their requests arrived. Each requester raises its request line and keeps it high until it sees its grant. The winner then owns the channel. Ownership is locked until that requester pulses its release line. Requests that come in while the channel is locked are recorded in an internal queue of requester indices. When the owner lets go, the oldest recorded requester takes over at the same clock edge.

Grants are registered. A request sampled at a rising edge is reflected on the grant vector just after that edge. The owner index output is meant to steer a data multiplexer outside the block. Only one requester can hold the channel at a time. A requester that is already waiting or already holding the channel is never recorded a second time, even if its request line stays high.

Top module: `fcfs_arbiter`

## Requirements
- R1: `grant_o` has at most one bit set. When a bit k is set, `owner_o` equals k.
- R2: After reset, `grant_o` is all zero, `owner_o` is 0 and no requester is waiting.
- R3: With no owner and no one waiting, the lowest-index requester among those whose request bit is high becomes the owner at the next rising edge. The other requesters are recorded in ascending index order.
- R4: Requests first seen in different cycles are served in the order of those cycles. Requests first seen in the same cycle are served in ascending index order.
- R5: A release is valid when the owner raises its own bit of `rel_i`. If anyone is waiting, the oldest waiting requester becomes the owner at that same edge, so the grant never drops while requesters are waiting.
- R6: A release bit raised by any requester other than the current owner has no effect. Grant and owner stay unchanged.
- R7: A requester that is waiting, or that owns the channel, is not recorded again while its request stays high. After one grant, a requester that released and dropped its request receives no further grant.
- R8: While no valid release occurs, the owner and the grant vector stay unchanged.
- R9: A valid release with no one waiting frees the channel. If other requesters' request bits are high in that same cycle, the lowest-index one becomes the owner at that edge. If none are high, `grant_o` goes to zero. The releasing owner's own request bit is not treated as a new request in its release cycle.
- R10: The waiting queue holds up to `N_REQ` indices and never overflows, even when every requester asks at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Request level, one bit per requester |
| rel_i | input | N_REQ | Release pulse, one bit per requester |
| grant_o | output | N_REQ | One-hot grant, zero when the channel is free |
| owner_o | output | IDX_W | Index of the current owner, valid while grant_o is non-zero |

## Verification
Several kinds of internal fault show up at the ports. A corrupted queue entry or count shows up as a grant to the wrong requester, or as a lost requester, at the next owner hand-over. Hand-overs happen every few cycles under the random stimulus, so such a fault surfaces within a few releases. A missing deduplication shows up as a second, unrequested grant to the same index after its first service. A mis-decoded release shows up in the very next cycle as a grant that moves without a valid release, or that stays put after one.

// File: rtl/fcfs_pkg.sv
package fcfs_pkg;
  localparam int unsigned MAX_REQ = 64;

  typedef logic [MAX_REQ-1:0] wide_mask_t;

  // index of the lowest set bit, 0 for an empty mask
  function automatic int unsigned first_set(input wide_mask_t m);
    first_set = 0;
    for (int i = MAX_REQ - 1; i >= 0; i--) begin
      if (m[i]) first_set = unsigned'(i);
    end
  endfunction
endpackage

// File: rtl/fcfs_arrival_detect.sv
module fcfs_arrival_detect #(
  parameter int N_REQ = 4,
  parameter int IDX_W = 2
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] pend_mask_i,
  input  logic             held_i,
  input  logic [IDX_W-1:0] owner_i,
  output logic [N_REQ-1:0] fresh_o
);
  // a request is fresh only if that requester is neither waiting nor owning
  for (genvar k = 0; k < N_REQ; k++) begin : g_bit
    assign fresh_o[k] = req_i[k] & ~pend_mask_i[k] &
                        ~(held_i && (owner_i == IDX_W'(k)));
  end
endmodule

// File: rtl/fcfs_index_queue.sv
module fcfs_index_queue #(
  parameter int N_REQ = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_i,
  input  logic [N_REQ-1:0] push_mask_i,
  output logic [IDX_W-1:0] head_o,
  output logic             empty_o,
  output logic [N_REQ-1:0] pend_mask_o,
  output logic [CNT_W-1:0] count_o
);
  logic [IDX_W-1:0] slot     [N_REQ];
  logic [IDX_W-1:0] nxt_slot [N_REQ];
  logic [CNT_W-1:0] cnt, nxt_cnt;
  logic [N_REQ-1:0] pend, nxt_pend;

  always_comb begin
    nxt_slot = slot;
    nxt_cnt  = cnt;
    nxt_pend = pend;
    if (pop_i) begin
      nxt_pend[slot[0]] = 1'b0;
      for (int i = 0; i < N_REQ - 1; i++) nxt_slot[i] = slot[i+1];
      nxt_cnt = cnt - 1'b1;
    end
    // same-cycle arrivals appended in ascending index order
    for (int k = 0; k < N_REQ; k++) begin
      if (push_mask_i[k]) begin
        for (int s = 0; s < N_REQ; s++) begin
          if (CNT_W'(s) == nxt_cnt) nxt_slot[s] = IDX_W'(k);
        end
        nxt_pend[k] = 1'b1;
        nxt_cnt     = nxt_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= '0;
      for (int i = 0; i < N_REQ; i++) slot[i] <= '0;
    end else begin
      cnt  <= nxt_cnt;
      pend <= nxt_pend;
      slot <= nxt_slot;
    end
  end

  assign head_o      = slot[0];
  assign empty_o     = (cnt == '0);
  assign pend_mask_o = pend;
  assign count_o     = cnt;

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(N_REQ));
  a_r7_mask_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_mask_o) == int'(count_o));
  a_r5_pop_only_when_filled: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
endmodule

// File: rtl/fcfs_owner_lock.sv
module fcfs_owner_lock #(
  parameter int N_REQ = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] rel_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] take_idx_i,
  output logic             held_o,
  output logic [IDX_W-1:0] owner_o,
  output logic             rel_hit_o
);
  // only the owner's own release bit counts
  assign rel_hit_o = held_o & rel_i[owner_o];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_o  <= 1'b0;
      owner_o <= '0;
    end else if (take_i) begin
      held_o  <= 1'b1;
      owner_o <= take_idx_i;
    end else if (rel_hit_o) begin
      held_o  <= 1'b0;
    end
  end

  a_r8_owner_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && !rel_hit_o) |=> (held_o && $stable(owner_o)));
  a_r6_foreign_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (held_o && rel_i != '0 && !rel_hit_o) |=> $stable(owner_o));
endmodule

// File: rtl/fcfs_arbiter.sv
module fcfs_arbiter #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] req_i,
  input  logic [N_REQ-1:0] rel_i,
  output logic [N_REQ-1:0] grant_o,
  output logic [IDX_W-1:0] owner_o
);
  localparam int CNT_W = $clog2(N_REQ + 1);

  // named internal events
  logic [N_REQ-1:0] fresh, push_mask, pend_mask, direct_oh;
  logic [IDX_W-1:0] head_idx, direct_idx, take_idx, owner;
  logic [CNT_W-1:0] q_count;
  logic             q_empty, held, rel_hit, free_now, pop, direct, take;
  fcfs_pkg::wide_mask_t fresh_wide;

  fcfs_arrival_detect #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_arrival (
    .req_i(req_i), .pend_mask_i(pend_mask), .held_i(held),
    .owner_i(owner), .fresh_o(fresh));

  always_comb begin
    fresh_wide = '0;
    fresh_wide[N_REQ-1:0] = fresh;
  end

  assign free_now   = !held || rel_hit;
  assign pop        = free_now && !q_empty;
  assign direct     = free_now && q_empty && (fresh != '0);
  assign direct_idx = IDX_W'(fcfs_pkg::first_set(fresh_wide));
  assign direct_oh  = direct ? (N_REQ'(1) << direct_idx) : '0;
  assign push_mask  = fresh & ~direct_oh;
  assign take       = pop || direct;
  assign take_idx   = pop ? head_idx : direct_idx;

  fcfs_index_queue #(.N_REQ(N_REQ), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_queue (
    .clk(clk), .rst_n(rst_n), .pop_i(pop), .push_mask_i(push_mask),
    .head_o(head_idx), .empty_o(q_empty), .pend_mask_o(pend_mask),
    .count_o(q_count));

  fcfs_owner_lock #(.N_REQ(N_REQ), .IDX_W(IDX_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .rel_i(rel_i), .take_i(take),
    .take_idx_i(take_idx), .held_o(held), .owner_o(owner),
    .rel_hit_o(rel_hit));

  assign grant_o = held ? (N_REQ'(1) << owner) : '0;
  assign owner_o = owner;

  a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r5_no_idle_while_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    !q_empty |-> held);
  a_r7_owner_not_waiting: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_mask & grant_o) == '0);
  a_r9_idle_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && req_i == '0) |=> !held);
endmodule

// File: tb/fcfs_arbiter_bench.sv
module fcfs_arbiter_bench;
  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  rel = '0;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int mq[N];
  int mlen = 0;
  int mown = 0;
  bit mheld = 1'b0;

  always #5 clk = ~clk;

  fcfs_arbiter #(.N_REQ(N)) u_fcfs_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rel_i(rel),
    .grant_o(grant), .owner_o(owner));

  function automatic bit in_queue(int k);
    for (int i = 0; i < mlen; i++) if (mq[i] == k) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] exp_grant();
    return mheld ? (N'(1) << mown) : '0;
  endfunction

  task automatic model_step(logic [N-1:0] r, logic [N-1:0] l);
    logic [N-1:0] fresh = '0;
    bit free;
    for (int k = 0; k < N; k++)
      fresh[k] = r[k] && !(mheld && mown == k) && !in_queue(k);
    free = !mheld || l[mown];
    if (free) begin
      if (mlen > 0) begin
        mown = mq[0];
        for (int i = 0; i < N - 1; i++) mq[i] = mq[i+1];
        mlen--;
        mheld = 1'b1;
      end else if (fresh != '0) begin
        for (int k = N - 1; k >= 0; k--) if (fresh[k]) mown = k;
        fresh[mown] = 1'b0;
        mheld = 1'b1;
      end else begin
        mheld = 1'b0;
      end
    end
    for (int k = 0; k < N; k++) if (fresh[k]) begin
      mq[mlen] = k;
      mlen++;
    end
  endtask

  task automatic check_ports(string tag);
    checks++;
    if (grant !== exp_grant()) begin
      fails++;
      $display("FAIL %s grant actual=%b expected=%b", tag, grant, exp_grant());
    end
    checks++;
    if ($countones(grant) > 1 || (grant != '0 && owner != IW'(mown))) begin
      fails++;
      $display("FAIL R1 owner actual=%0d grant=%b expected owner=%0d", owner, grant, mown);
    end
  endtask

  // drive at negedge, model the edge, check at the following negedge
  task automatic step(logic [N-1:0] r, logic [N-1:0] l, string tag);
    req = r;
    rel = l;
    model_step(r, l);
    @(posedge clk);
    @(negedge clk);
    check_ports(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2: reset state
    checks++;
    if (grant !== '0 || owner !== '0) begin
      fails++;
      $display("FAIL R2 grant=%b owner=%0d expected 0/0", grant, owner);
    end
    // R3: same-cycle requests from idle, lowest wins, rest queued ascending
    step(4'b1011, 4'b0000, "R3");
    step(4'b1010, 4'b0000, "R8");
    step(4'b1010, 4'b0001, "R5");   // 0 releases -> 1
    step(4'b1000, 4'b0010, "R5");   // 1 releases -> 3
    step(4'b0000, 4'b1000, "R9");   // 3 releases, empty -> idle
    // R6: foreign release
    step(4'b0100, 4'b0000, "R3");
    step(4'b0000, 4'b1011, "R6");
    // R9: release with a same-cycle new request goes direct
    step(4'b0010, 4'b0100, "R9");
    // R4: arrival order across cycles, ascending within a cycle
    step(4'b1000, 4'b0000, "R4");
    step(4'b1101, 4'b0000, "R4");
    step(4'b1101, 4'b0010, "R4");
    step(4'b0101, 4'b1000, "R4");
    step(4'b0100, 4'b0001, "R4");
    step(4'b0000, 4'b0100, "R4");
    // R7: held request not duplicated, no second grant
    step(4'b0001, 4'b0000, "R7");
    step(4'b0101, 4'b0000, "R7");
    step(4'b0101, 4'b0000, "R7");
    step(4'b0100, 4'b0001, "R7");
    step(4'b0000, 4'b0100, "R7");
    step(4'b0000, 4'b0000, "R7");
    // R10: everyone at once, queue filled to capacity of the others
    step(4'b1111, 4'b0000, "R10");
    for (int i = 0; i < N; i++) begin
      step('0, N'(1) << mown, "R10");
    end
    // random phase
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r, l;
      string tag;
      for (int k = 0; k < N; k++) r[k] = ($urandom % 4) == 0;
      l = '0;
      if (mheld && ($urandom % 2) == 0) l[mown] = 1'b1;
      if (($urandom % 8) == 0) l = l | N'($urandom);
      if (!mheld) tag = "R3";
      else if (l[mown]) tag = "R5";
      else if (l != '0) tag = "R6";
      else tag = "R8";
      step(r, l, tag);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule